// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard-control logic for an in-order, five-stage pipeline. The stages are fetch, decode with register read, execute, memory and write-back. Each cycle it looks at the register fields and write/load flags of the instructions in flight and makes two decisions. The first is where each of the two ALU operands of the execute-stage instruction comes from. The second is whether the front of the pipe must hold for one cycle.

Operands come from one of three places: the register-file value captured at decode, the result held in the EX/MEM pipeline register, or the result held in the MEM/WB pipeline register. No source is needed from the write-back stage output. The register file is written in the first half of a cycle and read in the second, so decode already sees the value being written back.

A hold is requested in two cases:
- A load in execute is followed directly by a decode instruction that reads the loaded register.
- The pipeline uses a single memory for instructions and data (build-time choice), and the instruction in the memory stage reads or writes data.

During a hold the PC and the IF/ID register keep their values, and a bubble with all controls at zero enters execute. When both causes occur in the same cycle, one hold is issued. The block is purely combinational.

Top module: `hazard_ctl`

## Requirements
- R1: Each operand select is two bits: 2'b00 means register-file value, 2'b10 means EX/MEM result, 2'b01 means MEM/WB result. The value 2'b11 never appears.
- R2: When the EX/MEM instruction writes a register (`mem_wr`=1) and its destination equals an execute source, that operand's select is 2'b10.
- R3: When only the MEM/WB instruction (`wb_wr`=1) has a destination equal to an execute source, that operand's select is 2'b01. A matching EX/MEM instruction that does not write is ignored.
- R4: When both the EX/MEM and MEM/WB destinations match the same source, the EX/MEM result wins (2'b10).
- R5: Register 0 never causes a forward or a load-use hold, whatever the write and load flags.
- R6: A load in execute (`exe_ld`=1) whose destination equals either decode source causes a hold. A non-load writer with the same destination does not.
- R7: With `UNIFIED_MEM`=1, a data load or store in the memory stage causes a hold.
- R8: A hold drives `pc_en`=0, `ifid_en`=0 and `bubble`=1 in the same cycle. With no hold these are 1, 1, 0. Coincident load-use and memory-conflict causes still give this single hold pattern.
- R9: With `UNIFIED_MEM`=0, memory-stage data accesses never cause a hold, while load-use holds still occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | REG_W | First source register of the decode instruction |
| dec_src_b | input | REG_W | Second source register of the decode instruction |
| exe_src_a | input | REG_W | First source register of the execute instruction |
| exe_src_b | input | REG_W | Second source register of the execute instruction |
| exe_dst | input | REG_W | Destination register of the execute instruction |
| exe_ld | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination register of the EX/MEM instruction |
| mem_wr | input | 1 | EX/MEM instruction writes a register |
| mem_ld | input | 1 | EX/MEM instruction reads data memory |
| mem_st | input | 1 | EX/MEM instruction writes data memory |
| wb_dst | input | REG_W | Destination register of the MEM/WB instruction |
| wb_wr | input | 1 | MEM/WB instruction writes a register |
| sel_a | output | 2 | Source select for ALU operand A |
| sel_b | output | 2 | Source select for ALU operand B |
| pc_en | output | 1 | PC update enable |
| ifid_en | output | 1 | IF/ID register write enable |
| bubble | output | 1 | Force the ID/EX controls to zero |

## Verification
The bench targets four cases, each with a distinct wrong-design symptom:
- Double match (R4): both bypass sources match one operand. A design with the wrong priority would hand the ALU the older MEM/WB value.
- Register 0 (R5): all write and load flags are set on register 0. A design that skipped the zero check would forward or hold on a value that must always read as zero.
- Load-use pairs (R6): a load is checked against a plain writer to the same register. A design that stalled on any writer would lose a cycle the bypass already covers, and one that missed either source would feed a stale operand.
- Memory-mode builds (R7, R9): both builds are driven with the same memory-stage accesses. A wrong mode decode would either collide fetch and data on a shared port or waste cycles on split memories.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_W       = 5,
  parameter bit UNIFIED_MEM = 1'b1
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] exe_src_a,
  input  logic [REG_W-1:0] exe_src_b,
  input  logic [REG_W-1:0] exe_dst,
  input  logic             exe_ld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr,
  input  logic             mem_ld,
  input  logic             mem_st,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             pc_en,
  output logic             ifid_en,
  output logic             bubble
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;
  localparam logic [1:0] SEL_RF = 2'b00;
  localparam logic [1:0] SEL_EM = 2'b10;
  localparam logic [1:0] SEL_MW = 2'b01;

  function automatic logic [1:0] pick_src(
    input logic [REG_W-1:0] src,
    input logic [REG_W-1:0] em_dst, input logic em_wr,
    input logic [REG_W-1:0] mw_dst, input logic mw_wr);
    if (src == ZERO_REG)                 return SEL_RF;
    else if (em_wr && em_dst == src)     return SEL_EM;
    else if (mw_wr && mw_dst == src)     return SEL_MW;
    else                                 return SEL_RF;
  endfunction

  assign sel_a = pick_src(exe_src_a, mem_dst, mem_wr, wb_dst, wb_wr);
  assign sel_b = pick_src(exe_src_b, mem_dst, mem_wr, wb_dst, wb_wr);

  logic load_use;
  logic mem_busy;
  logic hold;

  assign load_use = exe_ld && (exe_dst != ZERO_REG) &&
                    ((exe_dst == dec_src_a) || (exe_dst == dec_src_b));

  generate
    if (UNIFIED_MEM) begin : g_shared_port
      assign mem_busy = mem_ld | mem_st;
    end else begin : g_split_ports
      assign mem_busy = 1'b0;
    end
  endgenerate

  assign hold    = load_use | mem_busy;
  assign pc_en   = ~hold;
  assign ifid_en = ~hold;
  assign bubble  = hold;
endmodule

module hazard_ctl_chk #(
  parameter int REG_W       = 5,
  parameter bit UNIFIED_MEM = 1'b1
) (
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic [REG_W-1:0] exe_src_a,
  input logic [REG_W-1:0] exe_src_b,
  input logic [REG_W-1:0] exe_dst,
  input logic             exe_ld,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr,
  input logic             mem_ld,
  input logic             mem_st,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wr,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             pc_en,
  input logic             ifid_en,
  input logic             bubble
);
  logic known;
  assign known = !$isunknown({dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst,
                              exe_ld, mem_dst, mem_wr, mem_ld, mem_st, wb_dst, wb_wr,
                              sel_a, sel_b, pc_en, ifid_en, bubble});

  always_comb begin
    if (known) begin
      a_r1_sel_legal: assert (sel_a != 2'b11 && sel_b != 2'b11);
      if (mem_wr && mem_dst != '0 && mem_dst == exe_src_a)
        a_r4_newest_wins: assert (sel_a == 2'b10);
      if (exe_src_b == '0)
        a_r5_zero_reg: assert (sel_b == 2'b00);
      if (exe_ld && exe_dst != '0 && (exe_dst == dec_src_a || exe_dst == dec_src_b))
        a_r6_load_use: assert (bubble);
      a_r8_hold_shape: assert (pc_en == ifid_en && bubble == !pc_en);
      if (!UNIFIED_MEM && !exe_ld)
        a_r9_split_free: assert (!bubble);
    end
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.REG_W(REG_W), .UNIFIED_MEM(UNIFIED_MEM)) u_chk (
  .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .exe_src_a(exe_src_a),
  .exe_src_b(exe_src_b), .exe_dst(exe_dst), .exe_ld(exe_ld), .mem_dst(mem_dst),
  .mem_wr(mem_wr), .mem_ld(mem_ld), .mem_st(mem_st), .wb_dst(wb_dst), .wb_wr(wb_wr),
  .sel_a(sel_a), .sel_b(sel_b), .pc_en(pc_en), .ifid_en(ifid_en), .bubble(bubble));

// File: tb/hazard_ctl_tb.sv
module hazard_ctl_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [4:0] da, db, ea, eb, ed;
    logic       eld;
    logic [4:0] md;
    logic       mwr, mld, mst;
    logic [4:0] wd;
    logic       wwr;
    logic [1:0] xa, xb;
    logic       xhold;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R1 idle
    '{5'd0, 5'd0, 5'd1, 5'd3, 5'd0, 1'b0, 5'd1, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0}, // R2
    '{5'd0, 5'd0, 5'd2, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd4, 1'b1, 2'b00, 2'b01, 1'b0}, // R3
    '{5'd0, 5'd0, 5'd5, 5'd5, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 5'd5, 1'b1, 2'b10, 2'b10, 1'b0}, // R4
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0}, // R5
    '{5'd0, 5'd0, 5'd6, 5'd0, 5'd0, 1'b0, 5'd6, 1'b0, 1'b0, 1'b0, 5'd6, 1'b1, 2'b01, 2'b00, 1'b0}, // R3 non-writer ignored
    '{5'd7, 5'd0, 5'd0, 5'd0, 5'd7, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}, // R6 source a
    '{5'd0, 5'd8, 5'd0, 5'd0, 5'd8, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}, // R6 source b
    '{5'd9, 5'd0, 5'd0, 5'd0, 5'd9, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0}, // R6 non-load
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd10, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}, // R7 load
    '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}, // R7 store
    '{5'd3, 5'd0, 5'd0, 5'd0, 5'd3, 1'b1, 5'd11, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1}  // R8 combined
  };

  vec_t cur;
  logic [1:0] sa, sb, ssa, ssb;
  logic pe, ie, bb, spe, sie, sbb;

  hazard_ctl #(.REG_W(5), .UNIFIED_MEM(1'b1)) u_dut (
    .dec_src_a(cur.da), .dec_src_b(cur.db), .exe_src_a(cur.ea), .exe_src_b(cur.eb),
    .exe_dst(cur.ed), .exe_ld(cur.eld), .mem_dst(cur.md), .mem_wr(cur.mwr),
    .mem_ld(cur.mld), .mem_st(cur.mst), .wb_dst(cur.wd), .wb_wr(cur.wwr),
    .sel_a(sa), .sel_b(sb), .pc_en(pe), .ifid_en(ie), .bubble(bb));

  hazard_ctl #(.REG_W(5), .UNIFIED_MEM(1'b0)) u_split (
    .dec_src_a(cur.da), .dec_src_b(cur.db), .exe_src_a(cur.ea), .exe_src_b(cur.eb),
    .exe_dst(cur.ed), .exe_ld(cur.eld), .mem_dst(cur.md), .mem_wr(cur.mwr),
    .mem_ld(cur.mld), .mem_st(cur.mst), .wb_dst(cur.wd), .wb_wr(cur.wwr),
    .sel_a(ssa), .sel_b(ssb), .pc_en(spe), .ifid_en(sie), .bubble(sbb));

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(posedge clk);
    cur = v;
    @(negedge clk);
  endtask

  initial begin
    cur = '0;
    @(negedge clk);
    chk("R8 initial no hold", {5'd0, pe, ie, bb}, {5'd0, 3'b110});
    chk("R1 initial register-file selects", {4'd0, sa, sb}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      chk($sformatf("R2/R3/R4/R5 vec %0d sel_a", i), {6'd0, sa}, {6'd0, TBL[i].xa});
      chk($sformatf("R2/R3/R4/R5 vec %0d sel_b", i), {6'd0, sb}, {6'd0, TBL[i].xb});
      chk($sformatf("R6/R7/R8 vec %0d hold", i), {5'd0, pe, ie, bb},
          {5'd0, !TBL[i].xhold, !TBL[i].xhold, TBL[i].xhold});
    end

    // R9: split memories ignore memory-stage accesses
    drive(TBL[9]);
    chk("R9 split load no hold", {5'd0, spe, sie, sbb}, {5'd0, 3'b110});
    drive(TBL[10]);
    chk("R9 split store no hold", {5'd0, spe, sie, sbb}, {5'd0, 3'b110});
    drive(TBL[11]);
    chk("R9 split load-use still holds", {5'd0, spe, sie, sbb}, {5'd0, 3'b001});

    // R5: load into register 0 read by decode
    drive('{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0,
            2'b00, 2'b00, 1'b0});
    chk("R5 zero-reg load no hold", {5'd0, pe, ie, bb}, {5'd0, 3'b110});

    // R4: priority on operand b with a distinct match on operand a from MEM/WB
    drive('{5'd0, 5'd0, 5'd12, 5'd13, 5'd0, 1'b0, 5'd13, 1'b1, 1'b0, 1'b0, 5'd12, 1'b1,
            2'b01, 2'b10, 1'b0});
    chk("R4 mixed sel_a", {6'd0, sa}, 8'h01);
    chk("R4 mixed sel_b", {6'd0, sb}, 8'h02);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule